// File: doc/BRIEF.md
# Interrupt Flag and Aggregation Controller

This block gathers interrupt events from a set of peripherals and presents them to a processor as seven primary interrupt lines. It also names one winning vector. Every primary line has a flag and an enable. Its flag is set by a hardware event and is cleared when the processor acknowledges that vector. Two of the primary lines are shared. Each of them is fed by a group of four secondary sources, and each secondary source has its own enable and flag. Secondary flags are cleared only by software. Software writes a whole byte to the clear register, and a zero in a bit position clears that flag. A one has no effect, so a mask write cannot erase an event that arrives while the write is in flight.

A priority resolver ranks the pending, enabled primary lines. Each line takes a two-bit level, built from one bit in each of two priority registers. The line with the highest level wins. When two lines share a level, the lower line index wins. The processor reads the winner on `vec_idx` while `vec_valid` is high. It later returns that index on the acknowledge port.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all flags, enables and priority bits are zero. `irq_req` is zero and `vec_valid` is low.
- R2: A pulse on `ext_evt[k]` sets `pri_flag[k]` at the next clock edge. `irq_req[k]` is high only while `pri_flag[k]`, primary enable bit k (register 0, bits 6:0) and the global enable (register 0, bit 7) are all set.
- R3: A cycle with `ack_valid` high clears `pri_flag[ack_idx]` at the next edge. If a set request for the same line arrives in the same cycle, the flag stays set.
- R4: A pulse on `sec_evt[j]` sets `sec_flag[j]` at the next edge. An acknowledge does not clear a secondary flag.
- R5: Register 4 clears secondary flags. Each bit written as zero clears that flag. Each bit written as one leaves that flag unchanged.
- R6: If a secondary event and a zero-write clear hit the same flag in the same cycle, the flag stays set.
- R7: Secondary flags 3:0 feed primary line 2, and flags 7:4 feed primary line 6. Register 3 holds the secondary enables with the same bit layout. While any enabled secondary flag of a group is set, the primary flag of its line is set again every cycle, so an acknowledge does not drop it. A secondary flag whose enable is clear never sets the primary flag.
- R8: The level of line g is {register 2 bit g, register 1 bit g}. Among the requesting lines, `vec_idx` names one with the highest level.
- R9: Among requesting lines of equal highest level, `vec_idx` names the lowest index.
- R10: `vec_valid` is high exactly when `irq_req` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 primary enables and global enable, 1 priority low, 2 priority high, 3 secondary enables, 4 secondary clear) |
| wr_data | input | 8 | Register write data |
| ext_evt | input | 7 | Hardware event pulses for the primary lines |
| sec_evt | input | 8 | Hardware event pulses for the secondary sources |
| ack_valid | input | 1 | Processor vectoring acknowledge |
| ack_idx | input | 3 | Index of the line being acknowledged |
| irq_req | output | 7 | Enabled, pending primary lines |
| vec_valid | output | 1 | A vector is pending |
| vec_idx | output | 3 | Winning line index |
| pri_flag | output | 7 | Primary flags |
| sec_flag | output | 8 | Secondary flags |

## Verification
Two pairs of operations can land on the same flag in the same cycle. The first pair is a hardware set and a software zero-write clear. The second pair is a hardware set and a processor acknowledge. The bench drives the event pulse in the same cycle as the clearing write or the acknowledge. At the next falling edge it requires the flag to read one. It also acknowledges a shared line while an enabled secondary flag is still set, and requires that primary flag to stay set.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_PRI     = 7;
  localparam int PIDX_W      = $clog2(NUM_PRI);
  localparam int SEC_PER_GRP = 4;
  localparam int NUM_SEC_GRP = 2;
  localparam int NUM_SEC     = SEC_PER_GRP * NUM_SEC_GRP;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 3;
  localparam int LVL_W       = 2;

  localparam logic [ADDR_W-1:0] A_PEN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PLO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PHI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SCLR  = 3'd4;

  function automatic int grp_line(input int g);
    return (g == 0) ? 2 : 6;
  endfunction
endpackage

// File: rtl/irq_sec_bank.sv
module irq_sec_bank #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_wr && !clr_data[i];
    always_ff @(posedge clk) begin
      if (!rst_n)          flag[i] <= 1'b0;
      else if (evt[i])     flag[i] <= 1'b1;
      else if (clr_hit)    flag[i] <= 1'b0;
    end
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flag & $past(evt)) == $past(evt)));
  // R5
  ones_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && evt == '0) |=> ((flag & ~$past(flag)) == '0));
endmodule

// File: rtl/irq_pri_bank.sv
module irq_pri_bank #(
  parameter int N  = 7,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_vec,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  output logic [N-1:0]  flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic ack_hit;
    assign ack_hit = ack_valid && (ack_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)          flag[i] <= 1'b0;
      else if (set_vec[i]) flag[i] <= 1'b1;
      else if (ack_hit)    flag[i] <= 1'b0;
    end
  end

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && int'(ack_idx) < N && !set_vec[ack_idx]) |=> !flag[$past(ack_idx)]);
  // R2
  set_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flag & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N  = 7,
  parameter int IW = 3,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  lvl_lo,
  input  logic [N-1:0]  lvl_hi,
  output logic          valid,
  output logic [IW-1:0] idx
);
  logic [LW-1:0] best;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '0;
    for (int g = 0; g < N; g++) begin
      if (req[g] && (!valid || {lvl_hi[g], lvl_lo[g]} > best)) begin
        valid = 1'b1;
        idx   = IW'(g);
        best  = {lvl_hi[g], lvl_lo[g]};
      end
    end
  end

  // R8
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[idx]);
  // R9
  no_lower_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && idx != '0) |-> !(req[0] && {lvl_hi[0], lvl_lo[0]} >= {lvl_hi[idx], lvl_lo[idx]}));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_PRI-1:0] ext_evt,
  input  logic [NUM_SEC-1:0] sec_evt,
  input  logic              ack_valid,
  input  logic [PIDX_W-1:0] ack_idx,
  output logic [NUM_PRI-1:0] irq_req,
  output logic              vec_valid,
  output logic [PIDX_W-1:0] vec_idx,
  output logic [NUM_PRI-1:0] pri_flag,
  output logic [NUM_SEC-1:0] sec_flag
);
  logic [NUM_PRI-1:0] pen_q, plo_q, phi_q;
  logic               gie_q;
  logic [NUM_SEC-1:0] sen_q;
  logic [NUM_PRI-1:0] agg_req, set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q <= '0;
      gie_q <= 1'b0;
      plo_q <= '0;
      phi_q <= '0;
      sen_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PEN: begin
          pen_q <= wr_data[NUM_PRI-1:0];
          gie_q <= wr_data[DATA_W-1];
        end
        A_PLO: plo_q <= wr_data[NUM_PRI-1:0];
        A_PHI: phi_q <= wr_data[NUM_PRI-1:0];
        A_SEN: sen_q <= wr_data[NUM_SEC-1:0];
        default: ;
      endcase
    end
  end

  irq_sec_bank #(.N(NUM_SEC), .W(DATA_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .evt(sec_evt),
    .clr_wr(wr_en && wr_addr == A_SCLR), .clr_data(wr_data),
    .flag(sec_flag)
  );

  always_comb begin
    agg_req = '0;
    for (int g = 0; g < NUM_SEC_GRP; g++)
      agg_req[grp_line(g)] = |(sec_flag[g*SEC_PER_GRP +: SEC_PER_GRP] &
                               sen_q[g*SEC_PER_GRP +: SEC_PER_GRP]);
  end

  assign set_vec = ext_evt | agg_req;

  irq_pri_bank #(.N(NUM_PRI), .IW(PIDX_W)) u_pri (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .flag(pri_flag)
  );

  assign irq_req = pri_flag & pen_q & {NUM_PRI{gie_q}};

  irq_prio_resolver #(.N(NUM_PRI), .IW(PIDX_W), .LW(LVL_W)) u_res (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .lvl_lo(plo_q), .lvl_hi(phi_q),
    .valid(vec_valid), .idx(vec_idx)
  );

  // R7
  agg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sec_flag[3:0] & sen_q[3:0])) |=> pri_flag[2]);
  // R10
  valid_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == (irq_req != '0));
  // R4
  sec_survives_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !wr_en) |=> ((sec_flag & $past(sec_flag)) == $past(sec_flag)));
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [6:0] ext_evt;
  logic [7:0] sec_evt;
  logic       ack_valid;
  logic [2:0] ack_idx;
  logic [6:0] irq_req;
  logic       vec_valid;
  logic [2:0] vec_idx;
  logic [6:0] pri_flag;
  logic [7:0] sec_flag;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_evt(ext_evt), .sec_evt(sec_evt), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .irq_req(irq_req), .vec_valid(vec_valid), .vec_idx(vec_idx),
    .pri_flag(pri_flag), .sec_flag(sec_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ack(input logic [2:0] i);
    ack_valid = 1'b1; ack_idx = i;
    step();
    ack_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(irq_req == 0, "R1 irq_req", irq_req, 0);
    chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
    chk(pri_flag == 0 && sec_flag == 0, "R1 flags", {sec_flag, 1'b0, pri_flag}, 0);
  endtask

  task automatic t_ext();
    wr(3'd0, 8'h08);
    ext_evt = 7'h08; step(); ext_evt = '0;
    chk(pri_flag[3] == 1, "R2 flag set", pri_flag, 7'h08);
    chk(irq_req == 0, "R2 no global enable", irq_req, 0);
    wr(3'd0, 8'h88);
    chk(irq_req == 7'h08, "R2 line up", irq_req, 7'h08);
    chk(vec_valid && vec_idx == 3, "R10 vector", vec_idx, 3);
  endtask

  task automatic t_ack();
    ack(3'd3);
    chk(pri_flag[3] == 0, "R3 ack clears", pri_flag, 0);
    chk(vec_valid == 0, "R10 idle", vec_valid, 0);
    ext_evt = 7'h08; ack_valid = 1'b1; ack_idx = 3'd3;
    step();
    ext_evt = '0; ack_valid = 1'b0;
    chk(pri_flag[3] == 1, "R3 set beats ack", pri_flag, 7'h08);
    ack(3'd3);
  endtask

  task automatic t_sec();
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h84);
    sec_evt = 8'h01; step(); sec_evt = '0;
    chk(sec_flag == 8'h01, "R4 sec set", sec_flag, 8'h01);
    step();
    chk(pri_flag[2] == 1 && irq_req == 7'h04, "R7 line 2 raised", irq_req, 7'h04);
    ack(3'd2);
    chk(sec_flag == 8'h01, "R4 survives ack", sec_flag, 8'h01);
    chk(pri_flag[2] == 1, "R7 held by secondary", pri_flag, 7'h04);
  endtask

  task automatic t_w0c();
    wr(3'd4, 8'hFF);
    chk(sec_flag == 8'h01, "R5 ones ignored", sec_flag, 8'h01);
    wr(3'd4, 8'hFE);
    chk(sec_flag == 8'h00, "R5 zero clears", sec_flag, 0);
    ack(3'd2);
    chk(pri_flag[2] == 0 && irq_req == 0, "R7 line drops", irq_req, 0);
  endtask

  task automatic t_race();
    sec_evt = 8'h02;
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'hFD;
    step();
    sec_evt = '0; wr_en = 1'b0;
    chk(sec_flag == 8'h02, "R6 set beats clear", sec_flag, 8'h02);
    step(); step();
    chk(pri_flag[2] == 0, "R7 disabled secondary", pri_flag, 0);
    sec_evt = 8'h20; step(); sec_evt = '0;
    wr(3'd3, 8'h20);
    step();
    chk(pri_flag[6] == 1, "R7 group to line 6", pri_flag, 7'h40);
    wr(3'd4, 8'h00);
    chk(sec_flag == 0, "R5 clear all", sec_flag, 0);
    ack(3'd6);
    chk(pri_flag == 0, "R7 line 6 drops", pri_flag, 0);
  endtask

  task automatic t_prio();
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h20);
    ext_evt = 7'h32; step(); ext_evt = '0;
    chk(vec_valid && vec_idx == 5, "R8 highest level", vec_idx, 5);
    wr(3'd2, 8'h30);
    chk(vec_idx == 4, "R8 level 3 wins", vec_idx, 4);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    chk(vec_idx == 1, "R9 tie low index", vec_idx, 1);
    wr(3'd1, 8'h30);
    chk(vec_idx == 4, "R9 tie among level 1", vec_idx, 4);
    ack(3'd1); ack(3'd4); ack(3'd5);
    chk(vec_valid == 0 && irq_req == 0, "R10 all cleared", vec_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
    ext_evt = 0; sec_evt = 0; ack_valid = 0; ack_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_ext();
    t_ack();
    t_sec();
    t_w0c();
    t_race();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule